// File: doc/BRIEF.md
# Stereo Volume Mute and Power-Up Sequencer

This block is the control side of a digitally controlled stereo volume stage. It holds the 16-bit volume word, with one 8-bit attenuation code per channel. It decides when each channel's output buffer is connected to its pin and when it is switched over to the grounded termination. It also decides when the analog offset calibration has to run. The inputs are an active-low hardware mute, a zero-crossing strobe for each channel, a supply-good flag from an undervoltage comparator, a parallel volume write port, a soft-mute command and a calibration-done strobe from the analog side.

Power-up and hardware mute share one discipline: the volume word is cleared and a calibration is requested. Each channel is disconnected at its own next zero crossing, or after a fallback timeout of `TMO_CYC` cycles if no crossing comes. An output reconnects only when no mute source is active and the calibration has reported done. After reset, and again whenever the supply recovers, a power-on window of `POR_CYC` cycles follows, and volume writes are dropped during it. Writing code 0 to a channel is a software mute: the channel goes to full attenuation and stays connected. A soft-mute command walks both codes down one step at a time, with one step every `STEP_CYC` cycles.

Top module: `vol_mute_seq`

## Requirements
- R1: While reset is asserted, `vol_o` is 0, `out_en_o` is all zeros, `cal_busy_o` is 1 and `cal_req_o` is 1. On the first clock edge after reset is released, `cal_req_o` returns to 0.
- R2: After reset is released, or after the supply returns, volume writes on edges 1 to `POR_CYC` are ignored. A write on edge `POR_CYC+1` is the first one that takes effect.
- R3: A write with `wr_en_i` high loads `wr_data_i` into `vol_o` on the next edge. The left code is in bits [15:8] and the right code is in bits [7:0]. `zc_i[1]` and `out_en_o[1]` belong to the left channel, and index 0 belongs to the right channel.
- R4: While a mute source is active, a connected channel disconnects on the edge at which its own `zc_i` bit is sampled high. The other channel is not affected.
- R5: If no crossing arrives, a muted channel disconnects on the `TMO_CYC`-th edge after the mute source became active. It stays connected after edge `TMO_CYC-1`.
- R6: A high-to-low transition of `hw_mute_ni` while running produces the following on the next edge: a one-cycle `cal_req_o` pulse, `cal_busy_o` set and `vol_o` cleared to 0.
- R7: A disconnected output stays disconnected while `cal_busy_o` is high. `cal_busy_o` clears on the edge that samples `cal_done_i`. If no mute source is active, the output reconnects on the following edge.
- R8: Writing code 0 (software mute) sets `vol_o` to 0 and leaves `out_en_o` unchanged.
- R9: A `soft_mute_i` pulse starts a ramp. Each nonzero channel code drops by 1 on every `STEP_CYC`-th edge after the command, and the ramp stops when both codes reach 0. The outputs stay connected throughout.
- R10: A volume write during a ramp takes effect on the next edge and ends the ramp, so the written value then holds.
- R11: Dropping `supply_ok_i` clears `vol_o` on the next edge and mutes through the same zero-cross or timeout gating. Writes are ignored while the supply is low. When the supply returns, the next edge pulses `cal_req_o` and sets `cal_busy_o`, and then the R2 window runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power application) |
| hw_mute_ni | input | 1 | Hardware mute, active low |
| supply_ok_i | input | 1 | Supply above the undervoltage threshold |
| zc_i | input | NCH | Zero-crossing strobe per channel (1 = left) |
| cal_done_i | input | 1 | Offset calibration finished |
| wr_en_i | input | 1 | Volume write strobe |
| wr_data_i | input | NCH*CH_W | Volume word, left code in the upper byte |
| soft_mute_i | input | 1 | Start a stepwise ramp to code 0 |
| out_en_o | output | NCH | Output buffer connected, per channel |
| cal_req_o | output | 1 | One-cycle offset calibration request |
| cal_busy_o | output | 1 | Calibration outstanding |
| vol_o | output | NCH*CH_W | Current volume word |

## Verification
The mute gating is swept over every arrival time of a zero crossing from the first edge to beyond the timeout, alternating between the channels. This separates crossing-driven disconnects from timeout-driven ones, exposes any coupling between channels, and checks the exact edge of the timeout. Writes are held active across the whole power-on window, both after reset and after supply recovery, so that an off-by-one in the window shows up on a single edge. Soft-mute ramps start from several code pairs, including zero, one and unequal codes, and are checked at every step boundary. A write in the middle of a ramp shows whether the ramp really stops or keeps stepping.

// File: rtl/vms_pkg.sv
package vms_pkg;
  typedef enum logic [1:0] {
    PWR_POR = 2'd0,
    PWR_RUN = 2'd1,
    PWR_OFF = 2'd2
  } pwr_e;
endpackage

// File: rtl/vms_power.sv
module vms_power
  import vms_pkg::*;
#(
  parameter int unsigned POR_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic hw_mute_ni,
  input  logic cal_done_i,
  output logic run_o,
  output logic hm_evt_o,
  output logic cal_req_o,
  output logic cal_busy_o
);
  localparam int unsigned CW = $clog2(POR_CYC + 1);

  pwr_e           st_q, st_d;
  logic [CW-1:0]  cnt_q;
  logic           hm_prev_q;
  logic           por_entry;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_POR: if (cnt_q == CW'(POR_CYC - 1)) st_d = PWR_RUN;
      PWR_OFF: if (supply_ok_i) st_d = PWR_POR;
      default: ;
    endcase
    if (!supply_ok_i) st_d = PWR_OFF;
  end

  assign run_o     = (st_q == PWR_RUN) && supply_ok_i;
  assign hm_evt_o  = run_o && !hw_mute_ni && hm_prev_q;
  assign por_entry = (st_q == PWR_OFF) && (st_d == PWR_POR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= PWR_POR;
      cnt_q      <= '0;
      hm_prev_q  <= 1'b0;
      cal_req_o  <= 1'b1;
      cal_busy_o <= 1'b1;
    end else begin
      st_q      <= st_d;
      hm_prev_q <= hw_mute_ni;
      cnt_q     <= (st_q == PWR_POR && st_d == PWR_POR) ? cnt_q + 1'b1 : '0;
      cal_req_o <= hm_evt_o || por_entry;
      if (hm_evt_o || por_entry) cal_busy_o <= 1'b1;
      else if (cal_done_i)       cal_busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vms_gate.sv
module vms_gate #(
  parameter int unsigned TMO_CYC = 1800000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mute_req_i,
  input  logic zc_i,
  input  logic cal_busy_i,
  output logic conn_o
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_o <= 1'b0;
      tmo_q  <= '0;
    end else if (mute_req_i) begin
      if (conn_o) begin
        if (zc_i || tmo_q == TW'(TMO_CYC - 1)) begin
          conn_o <= 1'b0;
          tmo_q  <= '0;
        end else begin
          tmo_q <= tmo_q + 1'b1;
        end
      end else begin
        tmo_q <= '0;
      end
    end else begin
      tmo_q <= '0;
      if (!conn_o && !cal_busy_i) conn_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vms_volume.sv
module vms_volume #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CH_W     = 8,
  parameter int unsigned STEP_CYC = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                clr_i,
  input  logic                wr_en_i,
  input  logic [NCH*CH_W-1:0] wr_data_i,
  input  logic                soft_i,
  output logic [NCH*CH_W-1:0] vol_o
);
  localparam int unsigned SW = $clog2(STEP_CYC + 1);

  logic                ramp_q;
  logic [SW-1:0]       scnt_q;
  logic [NCH*CH_W-1:0] vol_dec;
  logic                all_low;
  logic                step;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign vol_dec[c*CH_W +: CH_W] = (vol_o[c*CH_W +: CH_W] == '0) ? '0
                                   : vol_o[c*CH_W +: CH_W] - CH_W'(1);
  end

  always_comb begin
    all_low = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (vol_o[c*CH_W +: CH_W] > CH_W'(1)) all_low = 1'b0;
  end

  assign step = ramp_q && (scnt_q == SW'(STEP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_o  <= '0;
      ramp_q <= 1'b0;
      scnt_q <= '0;
    end else if (!run_i || clr_i) begin
      vol_o  <= '0;
      ramp_q <= 1'b0;
      scnt_q <= '0;
    end else if (wr_en_i) begin
      vol_o  <= wr_data_i;
      ramp_q <= 1'b0;
      scnt_q <= '0;
    end else if (soft_i) begin
      ramp_q <= 1'b1;
      scnt_q <= '0;
    end else if (ramp_q) begin
      if (step) begin
        vol_o  <= vol_dec;
        scnt_q <= '0;
        if (all_low) ramp_q <= 1'b0;
      end else begin
        scnt_q <= scnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_mute_seq.sv
module vol_mute_seq #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CH_W     = 8,
  parameter int unsigned TMO_CYC  = 1800000,
  parameter int unsigned POR_CYC  = 10000,
  parameter int unsigned STEP_CYC = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_mute_ni,
  input  logic                supply_ok_i,
  input  logic [NCH-1:0]      zc_i,
  input  logic                cal_done_i,
  input  logic                wr_en_i,
  input  logic [NCH*CH_W-1:0] wr_data_i,
  input  logic                soft_mute_i,
  output logic [NCH-1:0]      out_en_o,
  output logic                cal_req_o,
  output logic                cal_busy_o,
  output logic [NCH*CH_W-1:0] vol_o
);
  logic run;
  logic hm_evt;
  logic mute_req;

  vms_power #(.POR_CYC(POR_CYC)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .hw_mute_ni (hw_mute_ni),
    .cal_done_i (cal_done_i),
    .run_o      (run),
    .hm_evt_o   (hm_evt),
    .cal_req_o  (cal_req_o),
    .cal_busy_o (cal_busy_o)
  );

  // any mute source, including power-up and supply loss
  assign mute_req = !hw_mute_ni || !run;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vms_gate #(.TMO_CYC(TMO_CYC)) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mute_req_i(mute_req),
      .zc_i      (zc_i[c]),
      .cal_busy_i(cal_busy_o),
      .conn_o    (out_en_o[c])
    );
  end

  vms_volume #(.NCH(NCH), .CH_W(CH_W), .STEP_CYC(STEP_CYC)) u_vol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (hm_evt),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .soft_i   (soft_mute_i),
    .vol_o    (vol_o)
  );
endmodule

// File: rtl/vol_mute_seq_chk.sv
module vol_mute_seq_chk #(
  parameter int unsigned NCH     = 2,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned TMO_CYC = 1800000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hw_mute_ni,
  input logic                supply_ok_i,
  input logic                run_i,
  input logic [NCH-1:0]      out_en_o,
  input logic                cal_req_o,
  input logic                cal_busy_o,
  input logic [NCH*CH_W-1:0] vol_o
);
  localparam int unsigned KW = $clog2(TMO_CYC + 2);

  // R6
  cal_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_req_o |=> !cal_req_o);

  // R6
  hw_mute_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $fell(hw_mute_ni)) |=> (cal_req_o && cal_busy_o && vol_o == '0));

  // R11
  supply_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> vol_o == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [KW-1:0] wait_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q <= '0;
      else if ((!hw_mute_ni || !run_i) && out_en_o[c]) wait_q <= wait_q + 1'b1;
      else wait_q <= '0;
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cal_busy_o && !out_en_o[c]) |=> !out_en_o[c]);

    // R4
    unmuted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_en_o[c] && hw_mute_ni && run_i) |=> out_en_o[c]);

    // R5
    tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q <= KW'(TMO_CYC));
  end
endmodule

bind vol_mute_seq vol_mute_seq_chk #(
  .NCH    (NCH),
  .CH_W   (CH_W),
  .TMO_CYC(TMO_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_mute_ni (hw_mute_ni),
  .supply_ok_i(supply_ok_i),
  .run_i      (run),
  .out_en_o   (out_en_o),
  .cal_req_o  (cal_req_o),
  .cal_busy_o (cal_busy_o),
  .vol_o      (vol_o)
);

// File: tb/sim_vol_mute_seq.sv
module sim_vol_mute_seq;
  localparam int TMO  = 12;
  localparam int POR  = 8;
  localparam int STEP = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hw_mute_ni = 1'b1;
  logic        supply_ok_i = 1'b1;
  logic [1:0]  zc_i = 2'b00;
  logic        cal_done_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        soft_mute_i = 1'b0;
  logic [1:0]  out_en_o;
  logic        cal_req_o;
  logic        cal_busy_o;
  logic [15:0] vol_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  vol_mute_seq #(.NCH(2), .CH_W(8), .TMO_CYC(TMO), .POR_CYC(POR), .STEP_CYC(STEP)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_mute_ni(hw_mute_ni), .supply_ok_i(supply_ok_i),
    .zc_i(zc_i), .cal_done_i(cal_done_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .soft_mute_i(soft_mute_i), .out_en_o(out_en_o), .cal_req_o(cal_req_o),
    .cal_busy_o(cal_busy_o), .vol_o(vol_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic recal();
    cal_done_i = 1'b1;
    tick(1);
    cal_done_i = 1'b0;
    chk("R7 busy cleared", 32'(cal_busy_o), 0);
    tick(1);
    chk("R7 reconnect", 32'(out_en_o), 3);
  endtask

  function automatic int dec(input int v, input int s);
    return (v > s) ? v - s : 0;
  endfunction

  task automatic mute_case(input int d);
    int ch = d % 2;
    int lim = (d < TMO) ? d : TMO;
    wr(16'h4040);
    hw_mute_ni = 1'b0;
    for (int k = 1; k <= TMO + 1; k++) begin
      zc_i = (k == d) ? (2'b01 << ch) : 2'b00;
      tick(1);
      chk("R4 crossing channel", 32'(out_en_o[ch]), 32'(k < lim));
      chk("R5 timeout channel", 32'(out_en_o[1-ch]), 32'(k < TMO));
      if (k == 1) begin
        chk("R6 cal_req", 32'(cal_req_o), 1);
        chk("R6 cal_busy", 32'(cal_busy_o), 1);
        chk("R6 vol cleared", 32'(vol_o), 0);
      end
      if (k == 2) chk("R6 pulse width", 32'(cal_req_o), 0);
    end
    zc_i = 2'b00;
    hw_mute_ni = 1'b1;
    tick(3);
    chk("R7 held while busy", 32'(out_en_o), 0);
    recal();
  endtask

  task automatic ramp_case(input int l, input int r);
    int mx = (l > r) ? l : r;
    wr(16'(l * 256 + r));
    soft_mute_i = 1'b1;
    tick(1);
    soft_mute_i = 1'b0;
    for (int s = 1; s <= mx + 1; s++) begin
      tick(STEP);
      chk("R9 ramp step", 32'(vol_o), 32'(dec(l, s) * 256 + dec(r, s)));
      chk("R9 stays connected", 32'(out_en_o), 3);
    end
  endtask

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 vol", 32'(vol_o), 0);
    chk("R1 out_en", 32'(out_en_o), 0);
    chk("R1 busy", 32'(cal_busy_o), 1);
    chk("R1 req", 32'(cal_req_o), 1);
    rst_ni = 1'b1;
    // R2 power-on window: write held across every edge
    wr_en_i = 1'b1; wr_data_i = 16'h1234;
    for (int k = 1; k <= POR + 1; k++) begin
      tick(1);
      if (k == 1) chk("R1 req drop", 32'(cal_req_o), 0);
      chk("R2 window", 32'(vol_o), (k <= POR) ? 32'h0 : 32'h1234);
    end
    wr_en_i = 1'b0;
    chk("R7 off until cal", 32'(out_en_o), 0);
    recal();

    // R3 write sweep
    for (int i = 0; i < 24; i++) begin
      logic [15:0] d = 16'(((i * 37) & 255) * 256 + ((i * 91 + 5) & 255));
      wr(d);
      chk("R3 write", 32'(vol_o), 32'(d));
    end
    // R8 software mute
    wr(16'h0000);
    chk("R8 vol zero", 32'(vol_o), 0);
    tick(5);
    chk("R8 still connected", 32'(out_en_o), 3);

    // R4 R5 R6 R7 crossing sweep
    for (int d = 1; d <= TMO + 2; d++) mute_case(d);

    // R9 ramps
    ramp_case(5, 3);
    ramp_case(1, 0);
    ramp_case(0, 0);
    ramp_case(7, 7);
    ramp_case(2, 9);

    // R10 abort
    wr(16'h0A0A);
    soft_mute_i = 1'b1; tick(1); soft_mute_i = 1'b0;
    tick(STEP * 2);
    chk("R10 ramp running", 32'(vol_o), 32'h0808);
    wr(16'h3030);
    chk("R10 write wins", 32'(vol_o), 32'h3030);
    tick(STEP * 4);
    chk("R10 ramp ended", 32'(vol_o), 32'h3030);

    // R11 supply loss
    wr(16'h5555);
    supply_ok_i = 1'b0; zc_i = 2'b11;
    tick(1);
    zc_i = 2'b00;
    chk("R11 vol cleared", 32'(vol_o), 0);
    chk("R11 gated mute", 32'(out_en_o), 0);
    wr_en_i = 1'b1; wr_data_i = 16'h7777;
    tick(3);
    chk("R11 write ignored", 32'(vol_o), 0);
    chk("R11 no req while off", 32'(cal_req_o), 0);
    supply_ok_i = 1'b1;
    tick(1);
    chk("R11 req on return", 32'(cal_req_o), 1);
    chk("R11 busy on return", 32'(cal_busy_o), 1);
    for (int j = 1; j <= POR + 1; j++) begin
      tick(1);
      if (j == 1) chk("R11 req pulse", 32'(cal_req_o), 0);
      chk("R11 R2 window again", 32'(vol_o), (j <= POR) ? 32'h0 : 32'h7777);
    end
    wr_en_i = 1'b0;
    chk("R11 off until cal", 32'(out_en_o), 0);
    recal();

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule